// File: doc/BRIEF.md
# Per-Area External Bus Sizing Unit

This unit sits between an internal access port and an external memory bus. A request of byte, word or longword size is turned into one or more external cycles of 8 or 16 bits. The external space has eight areas. Each area has its own bus width and its own byte order, held in a small configuration register file. A simple address/data/write-enable port writes that file and reads it back.

A boot-mode pin is captured during reset. When the part starts from external memory, area 0 must keep the settings it had at reset, so that the startup program can be fetched from it. In that mode, writes to area 0 are dropped. Area 0 is big endian in every mode.

When a request arrives, the unit copies the chosen area's settings. It then walks through the external cycles, one per clock, with the address rising by the bus width on each cycle. It places write bytes on the byte lanes, or collects read bytes, according to the area's byte order. A single done pulse ends the transfer.

Top module: `ext_bus_sizer`

## Requirements
- R1: While reset is held, the boot-mode pin (`boot_ext`, 1 = external boot) and the initial width pin (`init_wide`, 1 = 16 bits) are captured. After reset, every area reads back with its width equal to `init_wide` and big endian. Read-back bit 0 is the width (1 = 16 bits) and bit 1 is the byte order (1 = little endian). `busy`, `done` and `ext_valid` are low.
- R2: With external boot captured, a configuration write to area 0 has no effect: area 0 keeps reading back its reset values and keeps being accessed with them.
- R3: Areas 1 to 7 take both fields on any configuration write, in either boot mode. With internal boot, area 0 takes the width field, but its byte-order field always stays big endian.
- R4: The number of external cycles is 1 for a byte access. A word access takes 1 cycle on a 16-bit area and 2 on an 8-bit area. A longword access takes 2 cycles on a 16-bit area and 4 on an 8-bit area. Size code: 0 = byte, 1 = word, 2 = longword.
- R5: External cycles run on consecutive clocks, starting the clock after acceptance. The first cycle uses the request address, and each following cycle adds 2 (16-bit area) or 1 (8-bit area). `ext_wide` shows the area's width and `ext_write` shows the request direction.
- R6: In a big-endian area, the most significant byte of the sized value sits at the lowest external address. On the external data bus, the byte at `ext_addr` is on bits [7:0] and the byte at `ext_addr`+1 is on bits [15:8]. A lane not used in a cycle carries zero on writes.
- R7: In a little-endian area, the least significant byte of the sized value sits at the lowest external address, with the same lane convention as R6.
- R8: For a read, the bytes gathered over all cycles are assembled into `rdata`, right-aligned, with unused upper bytes zero. `done` is a single-cycle pulse on the clock after the last external cycle, and `rdata` is valid while `done` is high. For a write, `rdata` is zero at `done`.
- R9: A request is accepted only while `busy` is low. `busy` is high from the clock after acceptance through the last external cycle, and low when `done` is high. Requests presented while busy are ignored.
- R10: The area's width and byte order are copied at acceptance. A configuration write made during a transfer does not change that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_ext | input | 1 | Boot mode pin, 1 = start from external memory; captured in reset |
| init_wide | input | 1 | Initial width for all areas, 1 = 16 bits; captured in reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Area selected for configuration write and read-back |
| cfg_wdata | input | 2 | Bit 0 width, bit 1 little endian |
| cfg_rdata | output | 2 | Read-back of the selected area (combinational) |
| req_valid | input | 1 | Access request |
| req_area | input | 3 | Target area |
| req_addr | input | 26 | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 word, 2 longword |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 32 | Write value, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read value |
| ext_valid | output | 1 | External cycle active |
| ext_addr | output | 26 | External cycle address |
| ext_write | output | 1 | External cycle is a write |
| ext_wide | output | 1 | External cycle uses 16 bits |
| ext_wdata | output | 16 | External write lanes |
| ext_rdata | input | 16 | External read lanes, sampled in the cycle |

## Verification
The bench models external memory as a function of address, so every read lane has a known value. Each transfer is checked cycle by cycle against expected addresses and lanes, and at done against the assembled result. Byte, word and longword accesses are run on 8-bit and 16-bit areas in both byte orders. These patterns separate a wrong cycle count, a wrong address step and a mirrored byte order, because each of these gives different bytes.

Configuration writes are aimed at area 0 under both boot modes to expose a missing lock or a missing endian clamp. Writes during a transfer and requests presented while busy show whether settings are copied at acceptance and whether new requests are refused while busy. Random requests over random addresses and random configurations cover the remaining combinations.

// File: rtl/ebsu_pkg.sv
package ebsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } acc_size_t;

  // Bytes carried by a request of the given size code (code 3 treated as longword).
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    if (sz[1])      return 3'd4;
    else if (sz[0]) return 3'd2;
    else            return 3'd1;
  endfunction

  // External cycles needed for a size on a bus of 1 or 2 bytes.
  function automatic logic [2:0] beat_count(input logic [1:0] sz, input logic wide);
    logic [2:0] nb;
    nb = size_bytes(sz);
    if (nb <= (wide ? 3'd2 : 3'd1)) return 3'd1;
    return wide ? (nb >> 1) : nb;
  endfunction

  // Significance index (0 = least significant) of the byte at memory offset offs.
  function automatic logic [1:0] sig_index(input logic [1:0] offs, input logic [2:0] nb,
                                           input logic le);
    logic [2:0] mirrored;
    mirrored = nb - 3'd1 - {1'b0, offs};
    return le ? offs : mirrored[1:0];
  endfunction

endpackage

// File: rtl/ebsu_cfg_regs.sv
module ebsu_cfg_regs #(
  parameter int NUM_AREAS = 8,
  parameter int AREA_W    = $clog2(NUM_AREAS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_ext,
  input  logic              init_wide,
  input  logic              cfg_we,
  input  logic [AREA_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_wdata,
  output logic [1:0]        cfg_rdata,
  input  logic [AREA_W-1:0] sel_area,
  output logic              sel_wide,
  output logic              sel_le
);

  logic                 mode_ext_q;
  logic [NUM_AREAS-1:0] wide_vec;
  logic [NUM_AREAS-1:0] le_vec;
  logic                 area0_wr_hit;
  logic                 area0_locked;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_ext_q <= boot_ext;
  end

  assign area0_wr_hit = cfg_we && (cfg_addr == '0);
  assign area0_locked = mode_ext_q;

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
    logic wr_hit;
    logic wide_q;
    assign wr_hit = cfg_we && (cfg_addr == AREA_W'(i));
    if (i == 0) begin : g_boot_area
      // Width only, and only when not locked; byte order pinned to big endian.
      always_ff @(posedge clk) begin
        if (!rst_n)                       wide_q <= init_wide;
        else if (wr_hit && !area0_locked) wide_q <= cfg_wdata[0];
      end
      assign le_vec[i] = 1'b0;
    end else begin : g_free_area
      logic le_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wide_q <= init_wide;
          le_q   <= 1'b0;
        end else if (wr_hit) begin
          wide_q <= cfg_wdata[0];
          le_q   <= cfg_wdata[1];
        end
      end
      assign le_vec[i] = le_q;
    end
    assign wide_vec[i] = wide_q;
  end

  assign cfg_rdata = {le_vec[cfg_addr], wide_vec[cfg_addr]};
  assign sel_wide  = wide_vec[sel_area];
  assign sel_le    = le_vec[sel_area];

  assert_area0_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (area0_wr_hit && area0_locked) |=> $stable(wide_vec[0]));

  assert_cfg_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr != '0) |=> (wide_vec[$past(cfg_addr)] == $past(cfg_wdata[0])));

  assert_cfg_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr != '0) |=> (le_vec[$past(cfg_addr)] == $past(cfg_wdata[1])));

endmodule

// File: rtl/ebsu_seq.sv
module ebsu_seq
  import ebsu_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  input  logic              sel_wide,
  input  logic              sel_le,
  output logic              busy,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              ext_valid,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_write,
  output logic              ext_wide,
  output logic [15:0]       ext_wdata,
  input  logic [15:0]       ext_rdata
);

  logic              busy_q, done_q, wr_q, wide_q, le_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        size_q;
  logic [31:0]       wdata_q, acc_q;
  logic [1:0]        beat_q;
  logic [2:0]        beats_q;

  // Named events used by the sequencing logic and its assertions.
  logic              accept;
  logic              beat_last;
  logic [2:0]        nb;
  logic [1:0]        lane_en;
  logic [1:0]        lane_sig [2];

  assign accept    = req_valid && !busy_q;
  assign beat_last = busy_q && (({1'b0, beat_q} + 3'd1) == beats_q);
  assign nb        = size_bytes(size_q);

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      logic [1:0] offs;
      offs        = wide_q ? {beat_q[0], l[0]} : beat_q;
      lane_en[l]  = (l == 0) || (wide_q && nb > 3'd1);
      lane_sig[l] = sig_index(offs, nb, le_q);
    end
  end

  always_comb begin
    ext_wdata = '0;
    for (int l = 0; l < 2; l++) begin
      if (lane_en[l] && wr_q) ext_wdata[8*l +: 8] = wdata_q[8*lane_sig[l] +: 8];
    end
  end

  assign ext_valid = busy_q;
  assign ext_write = wr_q;
  assign ext_wide  = wide_q;
  assign ext_addr  = base_q + (wide_q ? ADDR_W'({beat_q, 1'b0}) : ADDR_W'(beat_q));
  assign busy      = busy_q;
  assign done      = done_q;
  assign rdata     = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      le_q    <= 1'b0;
      base_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      acc_q   <= '0;
      beat_q  <= '0;
      beats_q <= 3'd1;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        base_q  <= req_addr;
        size_q  <= req_size;
        wr_q    <= req_write;
        wdata_q <= req_wdata;
        wide_q  <= sel_wide;
        le_q    <= sel_le;
        beat_q  <= '0;
        beats_q <= beat_count(req_size, sel_wide);
        acc_q   <= '0;
      end else if (busy_q) begin
        if (!wr_q) begin
          for (int l = 0; l < 2; l++) begin
            if (lane_en[l]) acc_q[8*lane_sig[l] +: 8] <= ext_rdata[8*l +: 8];
          end
        end
        if (beat_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          beat_q <= beat_q + 2'd1;
        end
      end
    end
  end

  assert_beat_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ({1'b0, beat_q} < beats_q));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && beat_q != 2'd0) |->
      (ext_addr == $past(ext_addr) + (wide_q ? ADDR_W'(2) : ADDR_W'(1))));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !beat_last) |=> busy_q);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  assert_settings_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(wide_q) && $stable(le_q)));

endmodule

// File: rtl/ext_bus_sizer.sv
module ext_bus_sizer #(
  parameter int NUM_AREAS = 8,
  parameter int ADDR_W    = 26,
  localparam int AREA_W   = $clog2(NUM_AREAS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_ext,
  input  logic              init_wide,
  input  logic              cfg_we,
  input  logic [AREA_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_wdata,
  output logic [1:0]        cfg_rdata,
  input  logic              req_valid,
  input  logic [AREA_W-1:0] req_area,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              ext_valid,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_write,
  output logic              ext_wide,
  output logic [15:0]       ext_wdata,
  input  logic [15:0]       ext_rdata
);

  logic sel_wide, sel_le;

  ebsu_cfg_regs #(.NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_ext  (boot_ext),
    .init_wide (init_wide),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .sel_area  (req_area),
    .sel_wide  (sel_wide),
    .sel_le    (sel_le)
  );

  ebsu_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .sel_wide  (sel_wide),
    .sel_le    (sel_le),
    .busy      (busy),
    .done      (done),
    .rdata     (rdata),
    .ext_valid (ext_valid),
    .ext_addr  (ext_addr),
    .ext_write (ext_write),
    .ext_wide  (ext_wide),
    .ext_wdata (ext_wdata),
    .ext_rdata (ext_rdata)
  );

endmodule

// File: tb/sim_ext_bus_sizer.sv
module sim_ext_bus_sizer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_ext = 1'b1, init_wide = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [1:0]  cfg_wdata = '0;
  logic [1:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic [2:0]  req_area = '0;
  logic [25:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, ext_valid, ext_write, ext_wide;
  logic [31:0] rdata;
  logic [25:0] ext_addr;
  logic [15:0] ext_wdata, ext_rdata;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit wide_m [8];
  bit le_m [8];
  bit ext_mode;

  always #5 clk = ~clk;

  ext_bus_sizer u0 (.*);

  function automatic logic [7:0] mem_byte(input logic [25:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always_comb ext_rdata = {mem_byte(ext_addr + 26'd1), mem_byte(ext_addr)};

  function automatic int n_bytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic int n_cycles(input logic [1:0] sz, input bit wide);
    int bw = wide ? 2 : 1;
    int nb = n_bytes(sz);
    return (nb <= bw) ? 1 : nb / bw;
  endfunction

  // Byte of value stored at memory offset o.
  function automatic logic [7:0] byte_at(input logic [31:0] v, input int nb, input int o,
                                         input bit le);
    int shift = le ? o : (nb - 1 - o);
    return v[8*shift +: 8];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_model(input int a, input logic [1:0] d);
    if (a == 0) begin
      if (!ext_mode) wide_m[0] = d[0];
    end else begin
      wide_m[a] = d[0];
      le_m[a]   = d[1];
    end
  endtask

  task automatic do_reset(input bit boot, input bit iw);
    @(negedge clk);
    rst_n = 1'b0; boot_ext = boot; init_wide = iw;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ext_mode = boot;
    for (int i = 0; i < 8; i++) begin wide_m[i] = iw; le_m[i] = 0; end
  endtask

  task automatic cfg_write(input int a, input logic [1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    apply_model(a, d);
  endtask

  task automatic check_readback(input string tag);
    for (int i = 0; i < 8; i++) begin
      cfg_addr = 3'(i);
      #1;
      chk(cfg_rdata == {le_m[i], wide_m[i]}, tag, 32'(cfg_rdata), 32'({le_m[i], wide_m[i]}));
    end
  endtask

  // mid_cfg: write new settings to the same area during the first cycle (R10).
  // poke: present other requests while busy (R9).
  task automatic txn(input int area, input logic [25:0] addr, input logic [1:0] sz,
                     input bit wr, input logic [31:0] wd, input bit mid_cfg, input bit poke);
    bit ew = wide_m[area];
    bit el = le_m[area];
    int bw = ew ? 2 : 1;
    int nb = n_bytes(sz);
    int ecyc = n_cycles(sz, ew);
    int cyc = 0;
    int guard = 0;
    logic [31:0] exp_r = '0;
    @(negedge clk);
    req_valid = 1'b1; req_area = 3'(area); req_addr = addr; req_size = sz;
    req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && guard < 10) begin
      guard++;
      if (cfg_we) begin cfg_we = 1'b0; apply_model(area, cfg_wdata); end
      if (ext_valid) begin
        logic [25:0] ea = addr + 26'(cyc * bw);
        chk(busy, "R9 busy during cycle", 32'(busy), 1);
        chk(ext_addr == ea, "R5 address", 32'(ext_addr), 32'(ea));
        chk(ext_wide == ew && ext_write == wr, "R5 width/dir",
            32'({ext_wide, ext_write}), 32'({ew, wr}));
        if (wr) begin
          logic [15:0] ed = '0;
          for (int l = 0; l < 2; l++) begin
            int o = cyc * bw + l;
            if (l < bw && o < nb) ed[8*l +: 8] = byte_at(wd, nb, o, el);
          end
          chk(ext_wdata == ed, el ? "R7 write lanes" : "R6 write lanes",
              32'(ext_wdata), 32'(ed));
        end
        cyc++;
      end
      if (mid_cfg && cyc == 1 && guard == 1) begin
        cfg_we = 1'b1; cfg_addr = 3'(area); cfg_wdata = {~el, ~ew};
      end
      if (poke) begin
        req_valid = 1'b1; req_area = 3'($urandom_range(0, 7)); req_addr = $urandom;
        req_size = 2'd2; req_write = ~wr;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (cfg_we) begin cfg_we = 1'b0; apply_model(area, cfg_wdata); end
    chk(done, "R8 done seen", 32'(done), 1);
    chk(cyc == ecyc, mid_cfg ? "R10 cycle count" : "R4 cycle count", 32'(cyc), 32'(ecyc));
    chk(!busy, "R9 idle at done", 32'(busy), 0);
    if (!wr) begin
      for (int j = 0; j < nb; j++) exp_r[8*j +: 8] = mem_byte(addr + 26'(el ? j : nb - 1 - j));
    end
    chk(rdata == exp_r, el ? "R8/R7 read assembly" : "R8/R6 read assembly", rdata, exp_r);
    @(negedge clk);
    chk(!done && !ext_valid, "R8/R9 single done, no extra cycle",
        32'({done, ext_valid}), 0);
  endtask

  task automatic random_run(input int n);
    for (int k = 0; k < n; k++) begin
      if ($urandom_range(0, 3) == 0)
        cfg_write($urandom_range(0, 7), 2'($urandom_range(0, 3)));
      txn($urandom_range(0, 7), 26'($urandom), 2'($urandom_range(0, 2)),
          1'($urandom_range(0, 1)), $urandom, 1'b0, 1'($urandom_range(0, 5) == 0));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // External boot, 16-bit initial width
    do_reset(1'b1, 1'b1);
    #1;
    chk(!busy && !done && !ext_valid, "R1 idle after reset",
        32'({busy, done, ext_valid}), 0);
    check_readback("R1 reset readback");
    txn(0, 26'h0000100, 2'd2, 1'b0, '0, 1'b0, 1'b0);            // boot fetch, R6
    cfg_write(0, 2'b10);                                         // R2 ignored
    check_readback("R2 area0 locked");
    txn(0, 26'h0000204, 2'd2, 1'b0, '0, 1'b0, 1'b0);             // R2 still 16-bit BE
    cfg_write(1, 2'b10);
    cfg_write(2, 2'b11);
    cfg_write(3, 2'b00);
    check_readback("R3 areas writable");
    txn(1, 26'h0123456, 2'd2, 1'b1, 32'h11223344, 1'b0, 1'b0);   // R7 narrow LE
    txn(1, 26'h0123456, 2'd2, 1'b0, '0, 1'b0, 1'b0);             // R7 read
    txn(2, 26'h0000011, 2'd0, 1'b1, 32'hFFFFFFAB, 1'b0, 1'b0);   // byte, R6 upper lane 0
    txn(2, 26'h0000020, 2'd1, 1'b0, '0, 1'b0, 1'b0);             // word wide LE
    txn(3, 26'h03FFFFE, 2'd1, 1'b1, 32'h0000BEEF, 1'b0, 1'b0);   // R6 narrow BE
    txn(3, 26'h0001000, 2'd2, 1'b0, '0, 1'b1, 1'b0);             // R10
    txn(1, 26'h0002000, 2'd2, 1'b0, '0, 1'b0, 1'b1);             // R9 poke
    random_run(60);
    // Internal boot, 8-bit initial width
    do_reset(1'b0, 1'b0);
    #1;
    check_readback("R1 reset readback internal");
    cfg_write(0, 2'b11);                                         // R3 width taken, LE rejected
    check_readback("R3 area0 endian clamp");
    txn(0, 26'h0000300, 2'd2, 1'b1, 32'hA1B2C3D4, 1'b0, 1'b0);
    random_run(60);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule